// File: doc/BRIEF.md
# Two-Wire Clock Synthesizer Configuration Slave

This block is a two-wire serial slave that holds the settings of a clock synthesizer's phase-locked loop. The serial clock and data lines are sampled by a fast system clock, which must run at least eight times the serial clock rate. Bus conditions are detected in that clock domain, and the block answers to one fixed 7-bit device address. Every byte the slave accepts is acknowledged on an open-drain data output. `sda_pull_o` high means the pin is pulled low.

In a write, the first two bytes after the address are thrown away. The next three bytes fill three configuration slots, and anything after that is acknowledged but dropped. In a read, the slave returns the three slots in order.

The stored fields and a board-level multiplier select pin are combined into the feedback and reference divide ratios that the loop uses. When programming is disabled, a fixed multiplier chosen by the pin applies. The synthesizer's analog parts sit outside this block.

The control machine has these states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE`: shifting in a write byte.
- `ST_WR_ACK`: acknowledging a write byte.
- `ST_RD_BYTE`: driving a read byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: deaf until the next START.

It has these transitions:
- Any state goes to `ST_ADDR` on START and to `ST_IDLE` on STOP.
- `ST_ADDR` goes to `ST_ADDR_ACK` after eight bits with a matching address, or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` or `ST_RD_BYTE` by the direction bit.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on ACK or to `ST_IGNORE` on NACK.

Top module: `pll_cfg_slave`

## Requirements
- R1: After reset every slot is zero, including the program-enable bit and the bypass bit, and `sda_pull_o` is 0.
- R2: START is data falling while the clock is high, and STOP is data rising while the clock is high. An address byte whose upper seven bits are 1100101 is acknowledged, with a low bit of 0 meaning write and 1 meaning read. Any other address gets no acknowledge and no register change until the next START.
- R3: An acknowledge holds the data line low from just after the falling clock edge that ends the eighth bit until the next falling clock edge. `sda_pull_o` only changes while the clock is low.
- R4: In a write, the first two bytes after the address are not stored. Bytes three, four and five go to slot 0, slot 1 and slot 2. Later bytes are acknowledged and change nothing. A write that ends early leaves the slots it did not reach unchanged.
- R5: Slot 0 bit 7 is the Q bypass, bit 6 is the program enable and bits 5:0 are Q. Slot 1 is the 8-bit P. Slot 2 is a spare byte. The three are brought out on `q_bypass_o`, `pq_enable_o`, `q_value_o`, `p_value_o` and `spare_o`.
- R6: With the program enable set, `fb_div_o` = (P + 3) * 2. `ref_div_o` = Q + 2, or 1 when the bypass bit is set.
- R7: With the program enable clear, P and Q are ignored and `ref_div_o` = 1. `fb_div_o` = 16 when `mult_sel_i` = 0 and 8 when it is 1.
- R8: A repeated START restarts the address phase and the dummy-byte count. A STOP inside a byte discards the partial byte.
- R9: A read returns slot 0, slot 1 and slot 2 in order, MSB first, and releases the data line after the master does not acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| mult_sel_i | input | 1 | Fixed multiplier select: 0 for x16, 1 for x8 |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| q_bypass_o | output | 1 | Stored Q bypass bit |
| pq_enable_o | output | 1 | Stored program-enable bit |
| q_value_o | output | 6 | Stored Q field |
| p_value_o | output | 8 | Stored P field |
| spare_o | output | 8 | Stored spare byte |
| fb_div_o | output | 10 | Resolved feedback ratio |
| ref_div_o | output | 7 | Resolved reference ratio |

## Verification
The bench sweeps P, Q, bypass, enable and the select pin, and computes both ratios arithmetically. A wrong offset or a missed bypass shows up as a ratio mismatch.

It sends a repeated START after one dummy byte. A slave that kept its byte count across the restart would store a dummy byte into slot 0. It also sends a STOP four bits into a data byte; a slave that commits partial bytes would corrupt slot 0.

Trailing bytes and a mismatched address are sent to check that the spare slot is not overwritten and that no acknowledge appears. A read ending in NACK checks the slot order and that the line is released afterwards.

// File: rtl/pll_cfg_pkg.sv
`timescale 1ns / 1ps
package pll_cfg_pkg;
    localparam int P_BITS      = 8;
    localparam int Q_BITS      = 6;
    localparam int FB_BITS     = P_BITS + 2;
    localparam int REF_BITS    = Q_BITS + 1;
    localparam int BYTE_BITS   = 8;
    localparam int DUMMY_BYTES = 2;
    localparam int CFG_BYTES   = 3;
    localparam int BYP_BIT     = 7;
    localparam int EN_BIT      = 6;
    localparam int MULT_SEL0   = 16;
    localparam int MULT_SEL1   = 8;
    localparam logic [6:0] DEV_ADDR = 7'b1100101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns / 1ps
module twi_line_sync
    import pll_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output logic    scl_lvl,
    output logic    sda_lvl,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // idle bus is high on both lines, so reset to 1 to avoid a false START
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl  = scl_pipe[STAGES-1];
    assign sda_lvl  = sda_pipe[STAGES-1];
    assign ev.rise  = scl_lvl & ~scl_prev;
    assign ev.fall  = ~scl_lvl & scl_prev;
    assign ev.start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign ev.stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/pll_ratio_resolve.sv
`timescale 1ns / 1ps
module pll_ratio_resolve
    import pll_cfg_pkg::*;
(
    input  logic                pq_en,
    input  logic                q_byp,
    input  logic                sel_pin,
    input  logic [P_BITS-1:0]   p_val,
    input  logic [Q_BITS-1:0]   q_val,
    output logic [FB_BITS-1:0]  fb_div,
    output logic [REF_BITS-1:0] ref_div
);
    always_comb begin
        if (pq_en) begin
            fb_div  = (FB_BITS'(p_val) + FB_BITS'(3)) << 1;
            ref_div = q_byp ? REF_BITS'(1) : (REF_BITS'(q_val) + REF_BITS'(2));
        end else begin
            fb_div  = sel_pin ? FB_BITS'(MULT_SEL1) : FB_BITS'(MULT_SEL0);
            ref_div = REF_BITS'(1);
        end
    end
endmodule

// File: rtl/pll_cfg_slave.sv
`timescale 1ns / 1ps
module pll_cfg_slave
    import pll_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                mult_sel_i,
    output logic                sda_pull_o,
    output logic                q_bypass_o,
    output logic                pq_enable_o,
    output logic [Q_BITS-1:0]   q_value_o,
    output logic [P_BITS-1:0]   p_value_o,
    output logic [BYTE_BITS-1:0] spare_o,
    output logic [FB_BITS-1:0]  fb_div_o,
    output logic [REF_BITS-1:0] ref_div_o
);
    localparam int WR_LAST = DUMMY_BYTES + CFG_BYTES;
    localparam int WR_W    = $clog2(WR_LAST + 1);
    localparam int RD_W    = $clog2(CFG_BYTES);
    localparam int CNT_W   = $clog2(BYTE_BITS + 1);

    logic                              scl_lvl;
    logic                              sda_lvl;
    bus_ev_t                           ev;
    slv_state_e                        st_q;
    slv_state_e                        st_nxt;
    logic [CNT_W-1:0]                  bit_cnt;
    logic [BYTE_BITS-1:0]              rx_sh;
    logic [BYTE_BITS-2:0]              tx_sh;
    logic                              rw_q;
    logic                              nack_q;
    logic [WR_W-1:0]                   wr_idx;
    logic [RD_W-1:0]                   rd_idx;
    logic [RD_W-1:0]                   rd_idx_nxt;
    logic [CFG_BYTES-1:0][BYTE_BITS-1:0] cfg_q;
    logic [BYTE_BITS-1:0]              rd_word;
    logic [BYTE_BITS-1:0]              rd_word_nxt;
    logic                              byte_done;
    logic                              addr_hit;

    twi_line_sync #(.STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .ev      (ev)
    );

    assign byte_done   = (bit_cnt == CNT_W'(BYTE_BITS));
    assign addr_hit    = (rx_sh[BYTE_BITS-1:1] == DEV_ADDR);
    assign rd_idx_nxt  = (rd_idx == RD_W'(CFG_BYTES - 1)) ? '0 : rd_idx + RD_W'(1);
    assign rd_word     = cfg_q[rd_idx];
    assign rd_word_nxt = cfg_q[rd_idx_nxt];

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        if (ev.stop) begin
            st_nxt = ST_IDLE;
        end else if (ev.start) begin
            st_nxt = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_ADDR:     if (ev.fall && byte_done) st_nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (ev.fall) st_nxt = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (ev.fall && byte_done) st_nxt = ST_WR_ACK;
                ST_WR_ACK:   if (ev.fall) st_nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (ev.fall && bit_cnt == CNT_W'(BYTE_BITS - 1)) st_nxt = ST_RD_ACK;
                ST_RD_ACK:   if (ev.fall) st_nxt = nack_q ? ST_IGNORE : ST_RD_BYTE;
                default:     st_nxt = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rw_q       <= 1'b0;
            nack_q     <= 1'b0;
            wr_idx     <= '0;
            rd_idx     <= '0;
            cfg_q      <= '0;
        end else if (ev.stop) begin
            sda_pull_o <= 1'b0;
        end else if (ev.start) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            wr_idx     <= '0;
            rd_idx     <= '0;
        end else begin
            unique case (st_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (ev.rise) begin
                        rx_sh   <= {rx_sh[BYTE_BITS-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (ev.fall && byte_done) begin
                        bit_cnt <= '0;
                        if (st_q == ST_ADDR) begin
                            rw_q       <= rx_sh[0];
                            sda_pull_o <= addr_hit;
                        end else begin
                            sda_pull_o <= 1'b1;
                            if (wr_idx != WR_W'(WR_LAST)) wr_idx <= wr_idx + WR_W'(1);
                            for (int k = 0; k < CFG_BYTES; k++) begin
                                if (wr_idx == WR_W'(k + DUMMY_BYTES)) cfg_q[k] <= rx_sh;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.fall) begin
                        if (rw_q) begin
                            tx_sh      <= rd_word[BYTE_BITS-2:0];
                            sda_pull_o <= ~rd_word[BYTE_BITS-1];
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev.fall) sda_pull_o <= 1'b0;
                end
                ST_RD_BYTE: begin
                    if (ev.fall) begin
                        if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
                            sda_pull_o <= 1'b0;
                            bit_cnt    <= '0;
                        end else begin
                            sda_pull_o <= ~tx_sh[BYTE_BITS-2];
                            tx_sh      <= {tx_sh[BYTE_BITS-3:0], 1'b0};
                            bit_cnt    <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.rise) begin
                        nack_q <= sda_lvl;
                    end else if (ev.fall && !nack_q) begin
                        rd_idx     <= rd_idx_nxt;
                        tx_sh      <= rd_word_nxt[BYTE_BITS-2:0];
                        sda_pull_o <= ~rd_word_nxt[BYTE_BITS-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign q_bypass_o  = cfg_q[0][BYP_BIT];
    assign pq_enable_o = cfg_q[0][EN_BIT];
    assign q_value_o   = cfg_q[0][Q_BITS-1:0];
    assign p_value_o   = cfg_q[1][P_BITS-1:0];
    assign spare_o     = cfg_q[2];

    pll_ratio_resolve ratio_i (
        .pq_en   (pq_enable_o),
        .q_byp   (q_bypass_o),
        .sel_pin (mult_sel_i),
        .p_val   (p_value_o),
        .q_val   (q_value_o),
        .fb_div  (fb_div_o),
        .ref_div (ref_div_o)
    );
endmodule

// File: rtl/pll_cfg_slave_chk.sv
`timescale 1ns / 1ps
module pll_cfg_slave_chk
    import pll_cfg_pkg::*;
(
    input logic                               clk,
    input logic                               rst_n,
    input logic                               scl_lvl,
    input logic                               sda_pull_o,
    input logic                               pq_enable_o,
    input logic                               q_bypass_o,
    input logic                               mult_sel_i,
    input slv_state_e                         st_q,
    input logic [CFG_BYTES*BYTE_BITS-1:0]     cfg_flat,
    input logic [FB_BITS-1:0]                 fb_div_o,
    input logic [REF_BITS-1:0]                ref_div_o
);
    p_pull_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_lvl));

    p_quiet_when_unaddressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_IGNORE) |-> !sda_pull_o);

    p_cfg_written_only_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_flat) |-> ($past(st_q) == ST_WR_BYTE));

    p_bypass_forces_ref_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_enable_o && q_bypass_o) |-> (ref_div_o == REF_BITS'(1)));

    p_fixed_multiplier_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pq_enable_o |-> ((fb_div_o == (mult_sel_i ? FB_BITS'(MULT_SEL1) : FB_BITS'(MULT_SEL0)))
                          && (ref_div_o == REF_BITS'(1))));
endmodule

bind pll_cfg_slave pll_cfg_slave_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .sda_pull_o  (sda_pull_o),
    .pq_enable_o (pq_enable_o),
    .q_bypass_o  (q_bypass_o),
    .mult_sel_i  (mult_sel_i),
    .st_q        (st_q),
    .cfg_flat    (cfg_q),
    .fb_div_o    (fb_div_o),
    .ref_div_o   (ref_div_o)
);

// File: tb/pll_cfg_slave_tb_top.sv
`timescale 1ns / 1ps
module pll_cfg_slave_tb_top;
    import pll_cfg_pkg::*;

    localparam logic [7:0] ADDR_W = {DEV_ADDR, 1'b0};
    localparam logic [7:0] ADDR_R = {DEV_ADDR, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sel = 1'b1;
    logic        sda_pull_o;
    logic        q_bypass_o;
    logic        pq_enable_o;
    logic [5:0]  q_value_o;
    logic [7:0]  p_value_o;
    logic [7:0]  spare_o;
    logic [9:0]  fb_div_o;
    logic [6:0]  ref_div_o;
    wire         sda_bus;

    int n_chk = 0;
    int n_err = 0;
    int ack_cnt = 0;
    int hold_bad = 0;
    logic [7:0] tx_buf [8];

    assign sda_bus = m_sda & ~sda_pull_o;

    always #2 clk = ~clk;

    pll_cfg_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .mult_sel_i  (sel),
        .sda_pull_o  (sda_pull_o),
        .q_bypass_o  (q_bypass_o),
        .pq_enable_o (pq_enable_o),
        .q_value_o   (q_value_o),
        .p_value_o   (p_value_o),
        .spare_o     (spare_o),
        .fb_div_o    (fb_div_o),
        .ref_div_o   (ref_div_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; quarter();
        m_scl = 1'b1; quarter();
        m_sda = 1'b0; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; quarter();
        m_scl = 1'b1; quarter();
        m_sda = 1'b1; quarter();
        quarter();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; quarter();
        m_scl = 1'b1; quarter(); quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked, output logic held, output logic freed);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; quarter();
        m_scl = 1'b1; quarter();
        acked = (sda_bus == 1'b0);
        quarter();
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
        held = sda_pull_o;
        repeat (6) @(negedge clk);
        freed = !sda_pull_o;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            quarter();
            m_scl = 1'b1; quarter();
            d[i] = sda_bus;
            quarter();
            m_scl = 1'b0;
        end
        m_sda = !give_ack; quarter();
        m_scl = 1'b1; quarter(); quarter();
        m_scl = 1'b0; quarter();
        m_sda = 1'b1;
    endtask

    task automatic send_bytes(input int nb);
        logic a, h, f;
        for (int i = 0; i < nb; i++) begin
            write_byte(tx_buf[i], a, h, f);
            if (a) begin
                ack_cnt++;
                if (!h || !f) hold_bad++;
            end
        end
    endtask

    task automatic do_write(input logic [7:0] addr_byte, input int nb);
        logic a, h, f;
        ack_cnt = 0;
        hold_bad = 0;
        bus_start();
        write_byte(addr_byte, a, h, f);
        if (a) begin
            ack_cnt++;
            if (!h || !f) hold_bad++;
        end
        send_bytes(nb);
        bus_stop();
    endtask

    logic [7:0] sw_p;
    logic [5:0] sw_q;
    logic       sw_en;
    logic       sw_byp;
    int         fb_e;
    int         ref_e;
    logic [7:0] rd0, rd1, rd2;
    logic       ra, rh, rf;

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 bypass after reset", q_bypass_o, 0);
        chk("R1 enable after reset", pq_enable_o, 0);
        chk("R1 Q after reset", q_value_o, 0);
        chk("R1 P after reset", p_value_o, 0);
        chk("R1 spare after reset", spare_o, 0);
        chk("R1 data line released", sda_pull_o, 0);
        chk("R7 select 1 gives x8", fb_div_o, 8);
        chk("R7 reference 1 when not programmed", ref_div_o, 1);
        sel = 1'b0;
        @(negedge clk);
        chk("R7 select 0 gives x16", fb_div_o, 16);

        // R4 R5 full write with trailing bytes
        tx_buf = '{8'hA5, 8'h5A, 8'hC7, 8'h2D, 8'h96, 8'h11, 8'h22, 8'h33};
        do_write(ADDR_W, 8);
        chk("R2 address and all bytes acknowledged", ack_cnt, 9);
        chk("R3 acknowledge held and released", hold_bad, 0);
        chk("R5 bypass bit 7", q_bypass_o, 1);
        chk("R5 enable bit 6", pq_enable_o, 1);
        chk("R5 Q bits 5:0", q_value_o, 7);
        chk("R5 P from slot 1", p_value_o, 8'h2D);
        chk("R4 spare from fifth byte, extras ignored", spare_o, 8'h96);
        chk("R6 bypass forces reference 1", ref_div_o, 1);
        chk("R6 feedback ratio", fb_div_o, (8'h2D + 3) * 2);

        // R2 address mismatch
        tx_buf = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        do_write(8'hC8, 5);
        chk("R2 mismatched address not acknowledged", ack_cnt, 0);
        chk("R2 mismatch leaves P", p_value_o, 8'h2D);
        chk("R2 mismatch leaves spare", spare_o, 8'h96);
        chk("R2 mismatch leaves bypass", q_bypass_o, 1);

        // R6 R7 sweep
        for (int pi = 0; pi < 6; pi++) begin
            for (int m = 0; m < 4; m++) begin
                sw_p   = 8'(pi * 51);
                sw_q   = 6'((pi * 23 + m * 11) % 64);
                sw_en  = m[1];
                sw_byp = m[0];
                sel    = pi[0];
                tx_buf[0] = 8'h00;
                tx_buf[1] = 8'hFF;
                tx_buf[2] = {sw_byp, sw_en, sw_q};
                tx_buf[3] = sw_p;
                tx_buf[4] = 8'(pi + m);
                do_write(ADDR_W, 5);
                fb_e  = sw_en ? (int'(sw_p) + 3) * 2 : (sel ? 8 : 16);
                ref_e = sw_en ? (sw_byp ? 1 : int'(sw_q) + 2) : 1;
                if (sw_en) begin
                    chk("R6 feedback ratio sweep", fb_div_o, fb_e);
                    chk("R6 reference ratio sweep", ref_div_o, ref_e);
                end else begin
                    chk("R7 fixed multiplier sweep", fb_div_o, fb_e);
                    chk("R7 fixed reference sweep", ref_div_o, ref_e);
                end
                chk("R5 Q field sweep", q_value_o, sw_q);
            end
        end

        // R4 short write leaves the spare slot
        tx_buf = '{8'h00, 8'h00, 8'h43, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00};
        do_write(ADDR_W, 4);
        chk("R4 short write keeps spare", spare_o, 8);
        chk("R6 feedback after short write", fb_div_o, (16 + 3) * 2);
        chk("R6 reference after short write", ref_div_o, 3 + 2);

        // R8 stop inside a byte
        ack_cnt = 0;
        bus_start();
        write_byte(ADDR_W, ra, rh, rf);
        write_byte(8'h01, ra, rh, rf);
        write_byte(8'h02, ra, rh, rf);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R8 partial byte discarded (Q)", q_value_o, 3);
        chk("R8 partial byte discarded (bypass)", q_bypass_o, 0);

        // R8 repeated start restarts dummy count
        bus_start();
        write_byte(ADDR_W, ra, rh, rf);
        write_byte(8'h11, ra, rh, rf);
        tx_buf = '{8'h22, 8'h33, 8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        bus_start();
        write_byte(ADDR_W, ra, rh, rf);
        chk("R8 address after repeated start acknowledged", ra, 1);
        send_bytes(3);
        bus_stop();
        chk("R8 slot 0 after repeated start (Q)", q_value_o, 8'h0A);
        chk("R8 slot 0 after repeated start (enable)", pq_enable_o, 1);
        chk("R8 P untouched", p_value_o, 8'h10);

        // R9 read back
        bus_start();
        write_byte(ADDR_R, ra, rh, rf);
        chk("R9 read address acknowledged", ra, 1);
        read_byte(1'b1, rd0);
        read_byte(1'b1, rd1);
        read_byte(1'b0, rd2);
        quarter();
        chk("R9 released after NACK", sda_pull_o, 0);
        bus_stop();
        chk("R9 first byte is slot 0", rd0, 8'h4A);
        chk("R9 second byte is slot 1", rd1, 8'h10);
        chk("R9 third byte is slot 2", rd2, 8'h08);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule